// File: doc/BRIEF.md
# Debug Halt and Restart Controller

This block keeps track of whether a processor core is running, halted in debug state, or on its way back to running. It holds all of that in one 6-bit status code. Two reserved values mean "restarting" and "running after a restart". Every other value means the core is halted, and in that case the value names the cause of the halt. Halt causes arrive on request inputs: an external debug request, a halt instruction, a breakpoint, a watchpoint, a trap on software access to debug registers, an exception catch, and three pending-event sources (reset catch, OS-unlock catch and halting step).

A halt is accepted only when the debug-enable inputs permit it, and the permission depends on the core's security state. When a halt is taken, the block does four things. It captures the current instruction address and status word. It pulses a cross-halt trigger for the other cores. It stops prefetch and opens the debug instruction-transfer path. It records whether secure debug stays disabled for the duration of the halt.

Leaving debug state takes two steps. A restart request moves the status to "restarting", clears the pending events and pulses a branch to the saved address. One cycle later the status reaches "running" and the restarted flag rises.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: When `rst` is sampled high, the next cycle shows `dbg_status` = 6'b000010, `restarted` = 1, `insn_xfer_en` = 0, `xhalt_pulse` = 0, `branch_go` = 0 and `sec_dis` = 1.
- R2: A halt request is taken only under all of these conditions: `dbg_status` = 6'b000010, `dbl_lock` = 0, and `sec_dbg_en` = 1 when `in_secure` = 1 or `ns_dbg_en` = 1 when `in_secure` = 0. Otherwise the status is left unchanged.
- R3: Each halt reason has its own status code:
  - breakpoint 6'b000111
  - watchpoint 6'b101011
  - external request 6'b010011
  - halt instruction 6'b101111
  - software access 6'b110011
  - exception catch 6'b110111
  - reset catch 6'b100111
  - OS-unlock catch 6'b100011
  - step with `step_kind` 0 (normal) 6'b011011
  - step with `step_kind` 1 (exclusive) 6'b011111
  - step with `step_kind` 2 or 3 (no syndrome) 6'b111011
- R4: When several requests are taken in the same cycle, one reason is chosen. The order, highest first, is: external request, reset catch, OS-unlock catch, step, breakpoint, watchpoint, halt instruction, software access, exception catch.
- R5: The cycle after a halt is taken shows four results. The status holds the reason code. `restart_addr` and `saved_psr` hold `pc_in` and `psr_in` from the request cycle. `insn_xfer_en` = 1 and `restarted` = 0. `xhalt_pulse` is high for exactly that one cycle.
- R6: On halt entry, `sec_dis` is set as follows. It becomes 0 if `in_secure` = 1. Otherwise it becomes the inverse of `sec_dbg_en` when `has_top_el` = 1, and 1 when `has_top_el` = 0.
- R7: Exit from a halt takes two cycles. A `restart_req` while halted gives `dbg_status` = 6'b000001 with a one-cycle `branch_go` in the next cycle. The cycle after that gives `dbg_status` = 6'b000010, `restarted` = 1 and `insn_xfer_en` = 0.
- R8: An external request held high while halting is not permitted is taken in the cycle after permission appears.
- R9: Pulses on `rst_catch_evt`, `osu_catch_evt` and `step_evt` are each held as a pending event. A pending event halts the core once permitted, and `step_kind` is captured with the step event. All three pending events are cleared in the cycle a restart is accepted.
- R10: An OS-unlock event is pended only when the core is not halted. An event that arrives during the restarting cycle is kept.
- R11: Halt requests while halted or restarting leave the status and saved values unchanged. A `restart_req` while running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_dbg_req | input | 1 | External debug request (level, held until taken) |
| halt_insn | input | 1 | Halt instruction executed |
| bkpt_hit | input | 1 | Breakpoint match |
| wpt_hit | input | 1 | Watchpoint match |
| sw_dbg_trap | input | 1 | Software access to debug registers trapped |
| exc_catch | input | 1 | Exception catch event |
| step_evt | input | 1 | Halting step completed (pends) |
| step_kind | input | 2 | Step type: 0 normal, 1 exclusive, 2/3 no syndrome |
| rst_catch_evt | input | 1 | Reset catch event (pends) |
| osu_catch_evt | input | 1 | OS-unlock catch event (pends) |
| sec_dbg_en | input | 1 | Secure invasive debug enable |
| ns_dbg_en | input | 1 | Non-secure invasive debug enable |
| dbl_lock | input | 1 | Double lock active |
| in_secure | input | 1 | Core in secure state |
| has_top_el | input | 1 | Highest privilege level implemented |
| pc_in | input | ADDR_W | Current instruction address |
| psr_in | input | PSR_W | Status word to save |
| restart_req | input | 1 | Request to leave debug state |
| dbg_status | output | 6 | Status code |
| restart_addr | output | ADDR_W | Saved restart address |
| saved_psr | output | PSR_W | Saved status word |
| restarted | output | 1 | Restart complete flag |
| xhalt_pulse | output | 1 | One-cycle cross-halt trigger |
| insn_xfer_en | output | 1 | Prefetch stopped / instruction transfer enabled |
| sec_dis | output | 1 | Secure debug disabled for this halt |
| branch_go | output | 1 | One-cycle branch to `restart_addr` |

## Verification
The bench builds the block with `ADDR_W` = 8 and `PSR_W` = 8. At that width the captured address and status word can carry a distinct value for every test pattern.

The bench covers three areas:
- It sweeps all 32 combinations of the permission and security inputs. Each combination is checked for whether a halt is taken, for the secure-disable value and for the full two-step exit.
- It sweeps all 511 non-empty sets of the nine halt sources. The pending sources are set while the double lock blocks halting, and the bench then checks the chosen reason code against the priority order.
- After each exit it checks that no pending event survives.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int NSRC = 9;
  localparam logic [5:0] ST_RESTARTING = 6'b000001;
  localparam logic [5:0] ST_RUNNING    = 6'b000010;
  localparam logic [5:0] RSN_BKPT      = 6'b000111;
  localparam logic [5:0] RSN_EXTREQ    = 6'b010011;
  localparam logic [5:0] RSN_STEP_NRM  = 6'b011011;
  localparam logic [5:0] RSN_STEP_EXCL = 6'b011111;
  localparam logic [5:0] RSN_OSU       = 6'b100011;
  localparam logic [5:0] RSN_RSTCATCH  = 6'b100111;
  localparam logic [5:0] RSN_WPT       = 6'b101011;
  localparam logic [5:0] RSN_HLTINSN   = 6'b101111;
  localparam logic [5:0] RSN_SWACC     = 6'b110011;
  localparam logic [5:0] RSN_EXCCATCH  = 6'b110111;
  localparam logic [5:0] RSN_STEP_NOSY = 6'b111011;

  function automatic logic is_halted(input logic [5:0] st);
    return !(st == ST_RESTARTING || st == ST_RUNNING);
  endfunction

  function automatic logic [5:0] step_code(input logic [1:0] kind);
    case (kind)
      2'd0:    return RSN_STEP_NRM;
      2'd1:    return RSN_STEP_EXCL;
      default: return RSN_STEP_NOSY;
    endcase
  endfunction
endpackage

// File: rtl/dbg_halt_arb.sv
module dbg_halt_arb
  import dbg_halt_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic            running,
  input  logic            dbl_lock,
  input  logic            in_secure,
  input  logic            sec_dbg_en,
  input  logic            ns_dbg_en,
  input  logic [N-1:0]    req,
  input  logic [5:0]      code [N],
  output logic            allowed,
  output logic            take,
  output logic [5:0]      reason
);
  always_comb begin
    allowed = running && !dbl_lock && (in_secure ? sec_dbg_en : ns_dbg_en);
  end

  // index 0 has the highest priority
  always_comb begin
    reason = ST_RUNNING;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) reason = code[i];
    end
    take = allowed && (|req);
  end
endmodule

// File: rtl/dbg_halt_pend.sv
module dbg_halt_pend (
  input  logic       clk,
  input  logic       rst,
  input  logic       halted,
  input  logic       clr,
  input  logic       rc_evt,
  input  logic       osu_evt,
  input  logic       step_evt,
  input  logic [1:0] step_kind,
  output logic       rc_pend,
  output logic       osu_pend,
  output logic       step_pend,
  output logic [1:0] step_kind_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rc_pend     <= 1'b0;
      osu_pend    <= 1'b0;
      step_pend   <= 1'b0;
      step_kind_q <= 2'd0;
    end else if (clr) begin
      rc_pend   <= 1'b0;
      osu_pend  <= 1'b0;
      step_pend <= 1'b0;
    end else begin
      if (rc_evt) rc_pend <= 1'b1;
      if (osu_evt && !halted) osu_pend <= 1'b1;
      if (step_evt) begin
        step_pend   <= 1'b1;
        step_kind_q <= step_kind;
      end
    end
  end
endmodule

// File: rtl/dbg_halt_ctx.sv
module dbg_halt_ctx #(
  parameter int ADDR_W = 32,
  parameter int PSR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [PSR_W-1:0]  psr_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [PSR_W-1:0]  psr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      psr_q  <= '0;
    end else if (cap) begin
      addr_q <= pc_in;
      psr_q  <= psr_in;
    end
  end
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PSR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_dbg_req,
  input  logic              halt_insn,
  input  logic              bkpt_hit,
  input  logic              wpt_hit,
  input  logic              sw_dbg_trap,
  input  logic              exc_catch,
  input  logic              step_evt,
  input  logic [1:0]        step_kind,
  input  logic              rst_catch_evt,
  input  logic              osu_catch_evt,
  input  logic              sec_dbg_en,
  input  logic              ns_dbg_en,
  input  logic              dbl_lock,
  input  logic              in_secure,
  input  logic              has_top_el,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [PSR_W-1:0]  psr_in,
  input  logic              restart_req,
  output logic [5:0]        dbg_status,
  output logic [ADDR_W-1:0] restart_addr,
  output logic [PSR_W-1:0]  saved_psr,
  output logic              restarted,
  output logic              xhalt_pulse,
  output logic              insn_xfer_en,
  output logic              sec_dis,
  output logic              branch_go
);
  logic [5:0]      status_q;
  logic            halted, running, exit_go;
  logic            rc_p, osu_p, step_p;
  logic [1:0]      kind_q;
  logic [NSRC-1:0] req;
  logic [5:0]      code [NSRC];
  logic            allowed, take;
  logic [5:0]      reason;

  always_comb begin
    halted  = is_halted(status_q);
    running = (status_q == ST_RUNNING);
    exit_go = halted && restart_req;
  end

  dbg_halt_pend u_pend (
    .clk(clk), .rst(rst), .halted(halted), .clr(exit_go),
    .rc_evt(rst_catch_evt), .osu_evt(osu_catch_evt),
    .step_evt(step_evt), .step_kind(step_kind),
    .rc_pend(rc_p), .osu_pend(osu_p), .step_pend(step_p), .step_kind_q(kind_q)
  );

  // request table in priority order
  always_comb begin
    req = {exc_catch, sw_dbg_trap, halt_insn, wpt_hit, bkpt_hit,
           step_p, osu_p, rc_p, ext_dbg_req};
    code[0] = RSN_EXTREQ;
    code[1] = RSN_RSTCATCH;
    code[2] = RSN_OSU;
    code[3] = step_code(kind_q);
    code[4] = RSN_BKPT;
    code[5] = RSN_WPT;
    code[6] = RSN_HLTINSN;
    code[7] = RSN_SWACC;
    code[8] = RSN_EXCCATCH;
  end

  dbg_halt_arb #(.N(NSRC)) u_arb (
    .running(running), .dbl_lock(dbl_lock), .in_secure(in_secure),
    .sec_dbg_en(sec_dbg_en), .ns_dbg_en(ns_dbg_en),
    .req(req), .code(code), .allowed(allowed), .take(take), .reason(reason)
  );

  dbg_halt_ctx #(.ADDR_W(ADDR_W), .PSR_W(PSR_W)) u_ctx (
    .clk(clk), .rst(rst), .cap(take), .pc_in(pc_in), .psr_in(psr_in),
    .addr_q(restart_addr), .psr_q(saved_psr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q     <= ST_RUNNING;
      restarted    <= 1'b1;
      insn_xfer_en <= 1'b0;
      xhalt_pulse  <= 1'b0;
      sec_dis      <= 1'b1;
      branch_go    <= 1'b0;
    end else begin
      xhalt_pulse <= 1'b0;
      branch_go   <= 1'b0;
      if (take) begin
        status_q     <= reason;
        insn_xfer_en <= 1'b1;
        xhalt_pulse  <= 1'b1;
        restarted    <= 1'b0;
        sec_dis      <= in_secure ? 1'b0 : (has_top_el ? !sec_dbg_en : 1'b1);
      end else if (exit_go) begin
        status_q  <= ST_RESTARTING;
        branch_go <= 1'b1;
      end else if (status_q == ST_RESTARTING) begin
        status_q     <= ST_RUNNING;
        restarted    <= 1'b1;
        insn_xfer_en <= 1'b0;
      end
    end
  end

  assign dbg_status = status_q;

  assert_reset_running_R1: assert property (@(posedge clk)
    rst |=> (status_q == ST_RUNNING && restarted && !insn_xfer_en));

  assert_perm_R2: assert property (@(posedge clk) disable iff (rst)
    (running && !allowed) |=> (status_q == ST_RUNNING));

  assert_xhalt_code_R5: assert property (@(posedge clk) disable iff (rst)
    xhalt_pulse |-> (status_q[1:0] == 2'b11 && insn_xfer_en));

  assert_xhalt_single_R5: assert property (@(posedge clk) disable iff (rst)
    xhalt_pulse |=> !xhalt_pulse);

  assert_exit_seq_R7: assert property (@(posedge clk) disable iff (rst)
    (status_q == ST_RESTARTING) |=> (status_q == ST_RUNNING && restarted));

  assert_branch_R7: assert property (@(posedge clk) disable iff (rst)
    branch_go |-> (status_q == ST_RESTARTING));

  assert_halted_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (halted && !restart_req) |=> (status_q == $past(status_q)
                                  && restart_addr == $past(restart_addr)));
endmodule

// File: tb/sim_dbg_halt_ctrl.sv
module sim_dbg_halt_ctrl;
  localparam int AW = 8;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst;
  logic ext_dbg_req, halt_insn, bkpt_hit, wpt_hit, sw_dbg_trap, exc_catch;
  logic step_evt, rst_catch_evt, osu_catch_evt;
  logic [1:0] step_kind;
  logic sec_dbg_en, ns_dbg_en, dbl_lock, in_secure, has_top_el, restart_req;
  logic [AW-1:0] pc_in, restart_addr;
  logic [PW-1:0] psr_in, saved_psr;
  logic [5:0] dbg_status;
  logic restarted, xhalt_pulse, insn_xfer_en, sec_dis, branch_go;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dbg_halt_ctrl #(.ADDR_W(AW), .PSR_W(PW)) u0 (
    .clk(clk), .rst(rst), .ext_dbg_req(ext_dbg_req), .halt_insn(halt_insn),
    .bkpt_hit(bkpt_hit), .wpt_hit(wpt_hit), .sw_dbg_trap(sw_dbg_trap),
    .exc_catch(exc_catch), .step_evt(step_evt), .step_kind(step_kind),
    .rst_catch_evt(rst_catch_evt), .osu_catch_evt(osu_catch_evt),
    .sec_dbg_en(sec_dbg_en), .ns_dbg_en(ns_dbg_en), .dbl_lock(dbl_lock),
    .in_secure(in_secure), .has_top_el(has_top_el), .pc_in(pc_in),
    .psr_in(psr_in), .restart_req(restart_req), .dbg_status(dbg_status),
    .restart_addr(restart_addr), .saved_psr(saved_psr), .restarted(restarted),
    .xhalt_pulse(xhalt_pulse), .insn_xfer_en(insn_xfer_en), .sec_dis(sec_dis),
    .branch_go(branch_go)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    ext_dbg_req = 0; halt_insn = 0; bkpt_hit = 0; wpt_hit = 0;
    sw_dbg_trap = 0; exc_catch = 0; step_evt = 0; step_kind = 0;
    rst_catch_evt = 0; osu_catch_evt = 0; restart_req = 0;
    sec_dbg_en = 1; ns_dbg_en = 1; dbl_lock = 0; in_secure = 0; has_top_el = 1;
  endtask

  // two-step exit, checked (R7)
  task automatic leave();
    restart_req = 1;
    tick();
    restart_req = 0;
    chk("R7 restarting code", dbg_status, 6'b000001);
    chk("R7 branch pulse", branch_go, 1);
    tick();
    chk("R7 running code", dbg_status, 6'b000010);
    chk("R7 restarted flag", restarted, 1);
    chk("R7 xfer off", insn_xfer_en, 0);
    chk("R7 branch single", branch_go, 0);
  endtask

  function automatic logic [5:0] prio_code(input logic [8:0] m, input logic [1:0] k);
    logic [5:0] c [9];
    c[0] = 6'b010011; c[1] = 6'b100111; c[2] = 6'b100011;
    c[3] = (k == 0) ? 6'b011011 : (k == 1) ? 6'b011111 : 6'b111011;
    c[4] = 6'b000111; c[5] = 6'b101011; c[6] = 6'b101111;
    c[7] = 6'b110011; c[8] = 6'b110111;
    for (int i = 0; i < 9; i++) if (m[i]) return c[i];
    return 6'b000010;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1..: actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    quiet();
    pc_in = 0; psr_in = 0;
    rst = 1;
    @(negedge clk);
    tick();
    rst = 0;
    chk("R1 status", dbg_status, 6'b000010);
    chk("R1 restarted", restarted, 1);
    chk("R1 xfer", insn_xfer_en, 0);
    chk("R1 xhalt", xhalt_pulse, 0);
    chk("R1 branch", branch_go, 0);
    chk("R1 secdis", sec_dis, 1);

    // R11: restart while running ignored
    restart_req = 1; tick(); restart_req = 0;
    chk("R11 restart ignored status", dbg_status, 6'b000010);
    chk("R11 restart ignored branch", branch_go, 0);

    // R2/R5/R6 permission sweep
    for (int v = 0; v < 32; v++) begin
      logic ok;
      quiet();
      in_secure = v[0]; sec_dbg_en = v[1]; ns_dbg_en = v[2];
      dbl_lock = v[3]; has_top_el = v[4];
      pc_in = 8'h10 + 8'(v); psr_in = 8'hA0 ^ 8'(v);
      ok = !dbl_lock && (in_secure ? sec_dbg_en : ns_dbg_en);
      ext_dbg_req = 1;
      tick();
      ext_dbg_req = 0;
      if (ok) begin
        chk("R2 halted when permitted", dbg_status, 6'b010011);
        chk("R5 addr", restart_addr, 8'h10 + 8'(v));
        chk("R5 psr", saved_psr, 8'hA0 ^ 8'(v));
        chk("R5 xhalt", xhalt_pulse, 1);
        chk("R5 xfer", insn_xfer_en, 1);
        chk("R5 restarted low", restarted, 0);
        chk("R6 secdis", sec_dis, in_secure ? 0 : (has_top_el ? !sec_dbg_en : 1));
        tick();
        chk("R5 xhalt one cycle", xhalt_pulse, 0);
        leave();
      end else begin
        chk("R2 blocked", dbg_status, 6'b000010);
        chk("R2 blocked xhalt", xhalt_pulse, 0);
      end
    end

    // R8: held external request
    quiet(); dbl_lock = 1; ext_dbg_req = 1;
    repeat (3) tick();
    chk("R8 held blocked", dbg_status, 6'b000010);
    dbl_lock = 0; tick();
    chk("R8 taken on permit", dbg_status, 6'b010011);
    ext_dbg_req = 0;
    // R11: request while halted ignored
    pc_in = 8'h77; bkpt_hit = 1; tick(); bkpt_hit = 0;
    chk("R11 halted ignores status", dbg_status, 6'b010011);
    chk("R11 halted ignores addr", restart_addr, 8'h10 + 8'd31);
    // R10: OS-unlock event during restarting is kept
    restart_req = 1; tick(); restart_req = 0;
    chk("R7 restarting", dbg_status, 6'b000001);
    osu_catch_evt = 1; dbl_lock = 1; tick(); osu_catch_evt = 0;
    chk("R10 running", dbg_status, 6'b000010);
    dbl_lock = 0; tick();
    chk("R10 osu kept", dbg_status, 6'b100011);
    leave();
    tick();
    chk("R9 cleared after exit", dbg_status, 6'b000010);

    // R3/R4/R9 priority sweep over all source sets
    for (int m = 1; m < 512; m++) begin
      logic [8:0] mk;
      logic [1:0] k;
      mk = 9'(m); k = 2'(m % 4);
      quiet();
      dbl_lock = 1;
      ext_dbg_req = mk[0]; rst_catch_evt = mk[1]; osu_catch_evt = mk[2];
      step_evt = mk[3]; step_kind = k;
      tick();
      chk("R9 pend blocked", dbg_status, 6'b000010);
      rst_catch_evt = 0; osu_catch_evt = 0; step_evt = 0; step_kind = 0;
      dbl_lock = 0;
      bkpt_hit = mk[4]; wpt_hit = mk[5]; halt_insn = mk[6];
      sw_dbg_trap = mk[7]; exc_catch = mk[8];
      tick();
      chk("R3 R4 reason", dbg_status, prio_code(mk, k));
      quiet();
      leave();
      tick();
      chk("R9 pend cleared", dbg_status, 6'b000010);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule